// File: doc/BRIEF.md
# Strobed RAM Bus Sequencer

This block sits on the host side of a small 4-bit-wide static RAM that latches its address on the falling edge of an enable strobe. It takes one read or write request at a time on a valid/ready interface and turns it into a sequence on the RAM pins: the strobe, two active-low chip selects, the active-low write line and a drive enable for the shared data bus. Each phase of that sequence lasts a number of clock cycles set by 4-bit timing inputs. Read data returns on a one-cycle response pulse.

Writes are ordered so that the RAM's output drivers never turn on against the host's data. In the default order the write line falls while the selects are still high, so write data can be driven at once. A per-request mode bit picks the other order instead. In that order the selects fall first, and the host waits an output-turn-off interval with the bus released before it drives data. In both orders the write line and the selects rise together while the strobe is still low. Data stays driven for a programmed hold time after that.

Top module: `ram_strobe_seq`

## Requirements
- R1: Out of reset and while idle, the strobe, both selects and the write line are high, the data drive enable is low and `req_ready_o` is high.
- R2: A request is accepted only on a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low from the cycle after acceptance until the last precharge cycle has ended. A request held valid during that time does not start a second sequence.
- R3: Address, write data, direction and mode are latched at acceptance. `ram_addr_o` holds the latched address for the whole sequence. The strobe stays high for `cfg_setup_i`+1 cycles after acceptance and then falls.
- R4: After the strobe falls, the selects, write line and drive enable keep their idle levels for `cfg_ahold_i`+1 cycles (address hold).
- R5: A read drives both selects low with the write line high and the strobe low for `cfg_access_i`+1 cycles. It samples `ram_dq_i` at the end of the last of these cycles. `rsp_valid_o` is high for exactly one cycle, the first precharge cycle, and `rsp_data_o` carries the sampled value in that cycle.
- R6: In the default write order (mode bit 0), the write line goes low for one cycle with the selects still high and the data driven. Then the selects go low for `cfg_pulse_i`+1 cycles with the write line low and the data driven.
- R7: In the alternate write order (mode bit 1), the selects go low for one cycle with the write line high and the bus released. Then the write line goes low for `cfg_access_i`+1 cycles with the bus still released. Then the data is driven for `cfg_pulse_i`+1 cycles with the selects and write line low.
- R8: A write ends with the write line and both selects returning high in the same cycle while the strobe stays low. The data stays driven for `cfg_ahold_i`+1 cycles from that point.
- R9: Every sequence ends with `cfg_prech_i`+1 cycles in which the strobe, selects and write line are high and the bus is released. `req_ready_o` returns high in the following cycle.
- R10: The mode bit and the hold, pulse, precharge and access counts are taken at acceptance. Changing them during a sequence does not alter that sequence.
- R11: The data drive enable is never high in a cycle where the strobe and both selects are low and the write line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Request address |
| req_wdata_i | input | 4 | Write data |
| req_alt_order_i | input | 1 | 0 = write line before selects, 1 = selects first with turn-off wait |
| cfg_setup_i | input | 4 | Address setup count before the strobe falls |
| cfg_ahold_i | input | 4 | Address hold count and write data hold count |
| cfg_pulse_i | input | 4 | Write pulse count |
| cfg_prech_i | input | 4 | Strobe precharge count |
| cfg_access_i | input | 4 | Read access count and output turn-off count |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_data_o | output | 4 | Read data |
| ram_addr_o | output | 8 | RAM address |
| ram_strobe_n_o | output | 1 | RAM enable strobe, address latched on fall |
| ram_sel1_n_o | output | 1 | RAM select 1, active low |
| ram_sel2_n_o | output | 1 | RAM select 2, active low |
| ram_write_n_o | output | 1 | RAM write line, active low |
| ram_dq_o | output | 4 | Data toward the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | 4 | Data from the RAM |

## Verification
The reference model predicts every pin on every cycle for reads, default-order writes and alternate-order writes. It runs each of these with unit counts, all-zero counts and large counts, so a phase that lasts one cycle too many or too few shows up. Each write is read back from a small behavioural RAM that stores data only when the strobe, selects and write line are low and the drive enable is high. A write sent in the wrong order or without data driven therefore shows up as wrong read data. Requests held valid back to back test whether a second request can start a sequence while the first is running. Changing the mode bit and the counts in the middle of a sequence tests whether the values latched at acceptance are the ones used.

// File: rtl/ram_seq_pkg.sv
package ram_seq_pkg;
  localparam int TIM_W = 4;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SETUP, PH_AHOLD, PH_ACCESS, PH_WLEAD,
    PH_SELF, PH_ODIS, PH_WPULSE, PH_DHOLD, PH_PRECH
  } phase_e;

  // counts latched at acceptance; setup is consumed at once
  typedef struct packed {
    logic [TIM_W-1:0] ahold;
    logic [TIM_W-1:0] pulse;
    logic [TIM_W-1:0] prech;
    logic [TIM_W-1:0] access;
  } timing_t;
endpackage

// File: rtl/ram_seq_timer.sv
module ram_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ram_seq_capture.sv
module ram_seq_capture
  import ram_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          write_i,
  input  logic          alt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  timing_t       tim_i,
  output logic          write_o,
  output logic          alt_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output timing_t       tim_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      alt_o   <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      tim_o   <= '0;
    end else if (take_i) begin
      write_o <= write_i;
      alt_o   <= alt_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      tim_o   <= tim_i;
    end
  end
endmodule

// File: rtl/ram_seq_fsm.sv
module ram_seq_fsm
  import ram_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic             alt_i,
  input  logic [TIM_W-1:0] setup_now_i,
  input  timing_t          tim_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [TIM_W-1:0] load_val_o,
  output phase_e           phase_o,
  output logic             ready_o,
  output logic             strobe_n_o,
  output logic             sel_n_o,
  output logic             write_n_o,
  output logic             drive_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d       = ph_q;
    load_val_o = '0;
    unique case (ph_q)
      PH_IDLE:   if (start_i) begin ph_d = PH_SETUP; load_val_o = setup_now_i; end
      PH_SETUP:  if (done_i) begin ph_d = PH_AHOLD; load_val_o = tim_i.ahold; end
      PH_AHOLD:  if (done_i) begin
                   if (!is_write_i) begin ph_d = PH_ACCESS; load_val_o = tim_i.access; end
                   else if (alt_i)  ph_d = PH_SELF;
                   else             ph_d = PH_WLEAD;
                 end
      PH_ACCESS: if (done_i) begin ph_d = PH_PRECH;  load_val_o = tim_i.prech;  end
      PH_WLEAD:  if (done_i) begin ph_d = PH_WPULSE; load_val_o = tim_i.pulse;  end
      PH_SELF:   if (done_i) begin ph_d = PH_ODIS;   load_val_o = tim_i.access; end
      PH_ODIS:   if (done_i) begin ph_d = PH_WPULSE; load_val_o = tim_i.pulse;  end
      PH_WPULSE: if (done_i) begin ph_d = PH_DHOLD;  load_val_o = tim_i.ahold;  end
      PH_DHOLD:  if (done_i) begin ph_d = PH_PRECH;  load_val_o = tim_i.prech;  end
      PH_PRECH:  if (done_i) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  assign load_o = (ph_d != ph_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  // pin levels decoded straight from the phase register
  assign phase_o    = ph_q;
  assign ready_o    = (ph_q == PH_IDLE);
  assign strobe_n_o = (ph_q inside {PH_IDLE, PH_SETUP, PH_PRECH});
  assign sel_n_o    = !(ph_q inside {PH_ACCESS, PH_SELF, PH_ODIS, PH_WPULSE});
  assign write_n_o  = !(ph_q inside {PH_WLEAD, PH_ODIS, PH_WPULSE});
  assign drive_o    = (ph_q inside {PH_WLEAD, PH_WPULSE, PH_DHOLD});

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (strobe_n_o && sel_n_o && write_n_o && !drive_o));

  a_r11_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> (sel_n_o || !write_n_o || strobe_n_o));

  a_r6_write_before_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sel_n_o) && !write_n_o) |-> $past(!write_n_o));

  a_r7_alt_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sel_n_o) && write_n_o && is_write_i) |=> (!write_n_o && !drive_o));

  a_r8_end_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(write_n_o) |-> (sel_n_o && !strobe_n_o && drive_o));
endmodule

// File: rtl/ram_strobe_seq.sv
module ram_strobe_seq
  import ram_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_alt_order_i,
  input  logic [TIM_W-1:0] cfg_setup_i,
  input  logic [TIM_W-1:0] cfg_ahold_i,
  input  logic [TIM_W-1:0] cfg_pulse_i,
  input  logic [TIM_W-1:0] cfg_prech_i,
  input  logic [TIM_W-1:0] cfg_access_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_strobe_n_o,
  output logic          ram_sel1_n_o,
  output logic          ram_sel2_n_o,
  output logic          ram_write_n_o,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  input  logic [DW-1:0] ram_dq_i
);
  logic             start, cap_write, cap_alt, load, done, sel_n;
  logic [TIM_W-1:0] load_val;
  timing_t          tim_in, tim_cap;
  phase_e           phase;

  assign start  = req_valid_i && req_ready_o;
  assign tim_in = '{ahold: cfg_ahold_i, pulse: cfg_pulse_i,
                    prech: cfg_prech_i, access: cfg_access_i};

  ram_seq_capture #(.AW(AW), .DW(DW)) i_capture (
    .clk_i, .rst_ni, .take_i(start), .write_i(req_write_i), .alt_i(req_alt_order_i),
    .addr_i(req_addr_i), .wdata_i(req_wdata_i), .tim_i(tim_in),
    .write_o(cap_write), .alt_o(cap_alt), .addr_o(ram_addr_o),
    .wdata_o(ram_dq_o), .tim_o(tim_cap)
  );

  ram_seq_timer #(.W(TIM_W)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .val_i(load_val), .done_o(done)
  );

  ram_seq_fsm i_fsm (
    .clk_i, .rst_ni, .start_i(start), .is_write_i(cap_write), .alt_i(cap_alt),
    .setup_now_i(cfg_setup_i), .tim_i(tim_cap), .done_i(done),
    .load_o(load), .load_val_o(load_val), .phase_o(phase), .ready_o(req_ready_o),
    .strobe_n_o(ram_strobe_n_o), .sel_n_o(sel_n), .write_n_o(ram_write_n_o),
    .drive_o(ram_dq_oe_o)
  );

  assign ram_sel1_n_o = sel_n;
  assign ram_sel2_n_o = sel_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= (phase == PH_ACCESS) && done;
      if ((phase == PH_ACCESS) && done) rsp_data_o <= ram_dq_i;
    end
  end

  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_strobe_n_o |-> $stable(ram_addr_o));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r2_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: tb/test_ram_strobe_seq.sv
`timescale 1ns/1ps
module test_ram_strobe_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0, req_write_i = 1'b0, req_alt_order_i = 1'b0;
  logic [7:0] req_addr_i = '0;
  logic [3:0] req_wdata_i = '0;
  logic [3:0] cfg_setup_i = 4'd1, cfg_ahold_i = 4'd1, cfg_pulse_i = 4'd1;
  logic [3:0] cfg_prech_i = 4'd1, cfg_access_i = 4'd1;
  logic       req_ready_o, rsp_valid_o, ram_dq_oe_o;
  logic [3:0] rsp_data_o, ram_dq_o, ram_dq_i;
  logic [7:0] ram_addr_o;
  logic       ram_strobe_n_o, ram_sel1_n_o, ram_sel2_n_o, ram_write_n_o;

  ram_strobe_seq i_ram_strobe_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i,
    .req_wdata_i, .req_alt_order_i, .cfg_setup_i, .cfg_ahold_i, .cfg_pulse_i,
    .cfg_prech_i, .cfg_access_i, .rsp_valid_o, .rsp_data_o, .ram_addr_o,
    .ram_strobe_n_o, .ram_sel1_n_o, .ram_sel2_n_o, .ram_write_n_o,
    .ram_dq_o, .ram_dq_oe_o, .ram_dq_i
  );

  always #4 clk_i = ~clk_i;

  // behavioural RAM: stores only under a full write condition
  logic [3:0] ram_mem [256];
  logic [3:0] ref_mem [256];
  assign ram_dq_i = ram_mem[ram_addr_o];
  always @(posedge clk_i)
    if (!ram_strobe_n_o && !ram_sel1_n_o && !ram_sel2_n_o && !ram_write_n_o && ram_dq_oe_o)
      ram_mem[ram_addr_o] <= ram_dq_o;

  int checks = 0, errors = 0;
  bit accepted, finished = 0;
  string ctx = "reset";
  // {strobe,sel1,sel2,write,oe,ready,rvalid, addr[8], dq[4], rdata[4]}
  logic [22:0] exp_q[$];
  string tag_q[$];

  task automatic push_n(int n, logic [5:0] c, logic [7:0] a, logic [3:0] d,
                        logic [3:0] r, string t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({c[5], c[4], c[4], c[3:0], a, d, r});
      tag_q.push_back(t);
    end
  endtask

  task automatic compare();
    logic [22:0] e, g;
    string t;
    bit idle;
    idle = (exp_q.size() == 0);
    if (idle) begin e = {7'b1111010, 16'h0}; t = "R1"; end
    else begin e = exp_q[0]; t = tag_q[0]; end
    g = {ram_strobe_n_o, ram_sel1_n_o, ram_sel2_n_o, ram_write_n_o, ram_dq_oe_o,
         req_ready_o, rsp_valid_o, ram_addr_o, ram_dq_o, rsp_data_o};
    checks++;
    if (g[22:16] !== e[22:16]) begin
      errors++;
      $display("FAIL %s [%s] pins got %b expected %b", (g[17] !== e[17]) ? "R2" : t,
               ctx, g[22:16], e[22:16]);
    end
    if (!idle) begin
      checks++;
      if (g[15:8] !== e[15:8]) begin
        errors++;
        $display("FAIL R3 [%s] addr got %h expected %h", ctx, g[15:8], e[15:8]);
      end
    end
    if (e[18]) begin
      checks++;
      if (g[7:4] !== e[7:4]) begin
        errors++;
        $display("FAIL %s [%s] dq got %h expected %h", t, ctx, g[7:4], e[7:4]);
      end
    end
    if (e[16]) begin
      checks++;
      if (g[3:0] !== e[3:0]) begin
        errors++;
        $display("FAIL R5 [%s] rdata got %h expected %h", ctx, g[3:0], e[3:0]);
      end
    end
    checks++;  // R11 bus contention
    if (ram_dq_oe_o && !ram_strobe_n_o && !ram_sel1_n_o && !ram_sel2_n_o && ram_write_n_o) begin
      errors++;
      $display("FAIL R11 [%s] contention got oe=1 expected oe=0", ctx);
    end
  endtask

  task automatic advance();
    int s, h, pl, pr, ac;
    logic [7:0] a;
    logic [3:0] d;
    if (exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end else if (rst_ni && req_valid_i) begin
      accepted = 1;
      s = int'(cfg_setup_i); h = int'(cfg_ahold_i); pl = int'(cfg_pulse_i);
      pr = int'(cfg_prech_i); ac = int'(cfg_access_i);
      a = req_addr_i; d = req_wdata_i;
      push_n(s + 1, 6'b111000, a, 4'h0, 4'h0, "R3");
      push_n(h + 1, 6'b011000, a, 4'h0, 4'h0, "R4");
      if (!req_write_i) begin
        push_n(ac + 1, 6'b001000, a, 4'h0, 4'h0, "R5");
        push_n(1,      6'b111001, a, 4'h0, ref_mem[a], "R5");
        push_n(pr,     6'b111000, a, 4'h0, 4'h0, "R9");
      end else begin
        if (!req_alt_order_i) begin
          push_n(1,      6'b010100, a, d, 4'h0, "R6");
          push_n(pl + 1, 6'b000100, a, d, 4'h0, "R6");
        end else begin
          push_n(1,      6'b001000, a, d, 4'h0, "R7");
          push_n(ac + 1, 6'b000000, a, d, 4'h0, "R7");
          push_n(pl + 1, 6'b000100, a, d, 4'h0, "R7");
        end
        push_n(h + 1,  6'b011100, a, d, 4'h0, "R8");
        push_n(pr + 1, 6'b111000, a, d, 4'h0, "R9");
        ref_mem[a] = d;
      end
    end
  endtask

  // inputs for the coming edge are set before this is called, at a falling edge
  task automatic cycle();
    compare();
    advance();
    @(negedge clk_i);
  endtask

  task automatic do_req(bit wr, logic [7:0] a, logic [3:0] d, bit alt);
    req_valid_i = 1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    req_alt_order_i = alt;
    accepted = 0;
    while (!accepted) cycle();
    req_valid_i = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) cycle();
    cycle();
  endtask

  task automatic set_cfg(int s, int h, int pl, int pr, int ac);
    cfg_setup_i = 4'(s); cfg_ahold_i = 4'(h); cfg_pulse_i = 4'(pl);
    cfg_prech_i = 4'(pr); cfg_access_i = 4'(ac);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram_mem[i] = 4'((i * 5 + 3) % 16);
      ref_mem[i] = 4'((i * 5 + 3) % 16);
    end
    @(negedge clk_i);
    ctx = "R1 reset";
    repeat (3) cycle();
    rst_ni = 1;
    cycle();

    ctx = "R5 read unit counts";
    set_cfg(1, 1, 1, 1, 1);
    do_req(0, 8'h21, 4'h0, 0); wait_idle();

    ctx = "R6 default write then read";
    do_req(1, 8'h21, 4'hA, 0); wait_idle();
    do_req(0, 8'h21, 4'h0, 0); wait_idle();

    ctx = "R7 alternate write then read";
    set_cfg(2, 1, 3, 0, 2);
    do_req(1, 8'hC4, 4'h6, 1); wait_idle();
    do_req(0, 8'hC4, 4'h0, 1); wait_idle();

    ctx = "R4 R9 zero counts";
    set_cfg(0, 0, 0, 0, 0);
    do_req(1, 8'h00, 4'hF, 0); wait_idle();
    do_req(1, 8'hFF, 4'h1, 1); wait_idle();
    do_req(0, 8'h00, 4'h0, 0); wait_idle();
    do_req(0, 8'hFF, 4'h0, 0); wait_idle();

    ctx = "R3 large counts";
    set_cfg(15, 14, 15, 13, 15);
    do_req(1, 8'h5A, 4'h3, 1); wait_idle();
    do_req(0, 8'h5A, 4'h0, 0); wait_idle();

    ctx = "R2 back to back";
    set_cfg(1, 2, 1, 2, 3);
    do_req(0, 8'h10, 4'h0, 0);
    do_req(1, 8'h11, 4'h9, 0);
    do_req(0, 8'h11, 4'h0, 1);
    wait_idle();

    ctx = "R10 inputs changed mid sequence";
    set_cfg(2, 1, 2, 1, 2);
    do_req(1, 8'h77, 4'hC, 0);
    req_alt_order_i = 1; set_cfg(9, 9, 9, 9, 9);
    cycle(); cycle();
    set_cfg(0, 3, 0, 3, 0);
    wait_idle();
    set_cfg(1, 1, 1, 1, 1);
    do_req(0, 8'h77, 4'h0, 0);
    req_write_i = 1; req_addr_i = 8'h00; set_cfg(7, 7, 7, 7, 7);
    wait_idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule